// File: doc/BRIEF.md
# Multi-channel countdown interrupt counter

This block watches a small group of asynchronous input lines and turns each one into either a divided interrupt source or a direct per-edge interrupt source. In counter mode a channel counts rising edges on its line. After a programmed number of edges it emits a one-cycle interrupt pulse, reloads itself and keeps counting. Each channel's present count can be read at any time. The readout is one below the number of edges still needed.

Programmed counts are first written into per-channel shadow registers. They reach the running counter only when a refresh pulse arrives. A select word picks which channels the refresh touches: a channel takes part when its bit is 0. Per-channel mask, unmask and pending-clear strobes gate the interrupt pulses. Unmasking through the unmask strobe rather than through refresh switches the channel to per-edge mode.

Top module: `cnt_irq_top`

## Requirements
- R1: After reset every present value reads 0 and no interrupt is raised. Every channel starts masked and in per-edge mode, so an input edge produces no interrupt.
- R2: Each input passes through a two-flip-flop synchroniser and then a rising-edge detector. A line held high for many cycles counts exactly once.
- R3: Writing a channel's shadow set value (`sv_we_i` bit c, data `sv_wdata_i`) leaves its present value and its terminal count unchanged until the next refresh of that channel.
- R4: While `refresh_i` is high, each channel whose `refresh_ctl_i` bit is 0 loads present value = shadow - 1. That channel is also unmasked, its pending request is dropped without an interrupt, and it enters counter mode. A channel whose bit is 1 is left as it was.
- R5: In counter mode each rising edge lowers the present value by one. An edge that arrives while it reads 0 raises a one-cycle `irq_o` pulse and reloads shadow - 1, so a set value N gives one interrupt every N edges.
- R6: A set value of 0 means 2^CNT_W edges. The present value reads all ones after refresh or reload.
- R7: When a refresh for a channel and an input edge on it fall in the same cycle, the edge is discarded and no interrupt is raised.
- R8: A masked channel in counter mode keeps counting and reloading. A terminal count sets an internal pending flag instead of pulsing `irq_o`.
- R9: `mask_clr_i` unmasks a channel and puts it in per-edge mode. A pending request is delivered as one `irq_o` pulse on the next cycle. After that, every rising edge pulses `irq_o` and the present value holds.
- R10: `pend_clr_i` discards a pending request, so a later unmask raises no interrupt.
- R11: `mask_set_i` takes priority over `mask_clr_i` in the same cycle. `pend_clr_i` arriving together with an unmask discards the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_CH | Asynchronous input lines, one per channel |
| sv_we_i | input | NUM_CH | Shadow set-value write enables |
| sv_wdata_i | input | CNT_W | Shadow set-value write data |
| refresh_i | input | 1 | Single-cycle refresh command |
| refresh_ctl_i | input | NUM_CH | Refresh select, 0 = refresh that channel |
| mask_set_i | input | NUM_CH | Mask strobes |
| mask_clr_i | input | NUM_CH | Unmask strobes (select per-edge mode) |
| pend_clr_i | input | NUM_CH | Pending-request discard strobes |
| irq_o | output | NUM_CH | One-cycle interrupt pulses |
| pv_o | output | NUM_CH*CNT_W | Present values, channel c at bits c*CNT_W and up |

## Verification
The bench builds the block with NUM_CH = 4, SYNC_STAGES = 2 and CNT_W narrowed to 8. With that width, a set value of zero needs only 256 edges, so the full wrap from 0 to all ones and the interrupt on the 256th edge are exercised directly. The default four channels let refresh select words be checked on touched and untouched channels side by side. The two-stage synchroniser fixes the three-cycle latency from an input edge to a count change, and the directed tasks time their refresh-versus-edge collision on that latency.

// File: rtl/cnt_irq_pkg.sv
package cnt_irq_pkg;
  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_COUNT = 1'b1
  } ch_mode_e;
endpackage

// File: rtl/cnt_irq_sync_edge.sv
module cnt_irq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cnt_irq_chan.sv
module cnt_irq_chan
  import cnt_irq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             sv_we_i,
  input  logic [CNT_W-1:0] sv_wdata_i,
  input  logic             load_i,
  input  logic             mask_set_i,
  input  logic             mask_clr_i,
  input  logic             pend_clr_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] pv_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] shadow_q, active_q, pv_q;
  logic [CNT_W-1:0] active_d, pv_d;
  ch_mode_e         mode_q, mode_d;
  logic             masked_q, masked_d;
  logic             pend_q, pend_d;
  logic             irq_q, irq_d;
  logic             terminal, hit, unmask, pend_eff;

  assign terminal = (pv_q == '0);
  assign hit      = rise_i & ((mode_q == MODE_EDGE) | terminal);
  assign unmask   = mask_clr_i & ~mask_set_i & masked_q;
  assign pend_eff = pend_q | (hit & masked_q);

  always_comb begin
    active_d = active_q;
    pv_d     = pv_q;
    mode_d   = mode_q;
    masked_d = masked_q;
    pend_d   = pend_q;
    irq_d    = 1'b0;
    if (load_i) begin
      // refresh wins over a coincident edge
      active_d = shadow_q;
      pv_d     = shadow_q - ONE;
      mode_d   = MODE_COUNT;
      masked_d = 1'b0;
      pend_d   = 1'b0;
    end else begin
      if (mode_q == MODE_COUNT && rise_i)
        pv_d = terminal ? (active_q - ONE) : (pv_q - ONE);
      if (mask_set_i) begin
        masked_d = 1'b1;
      end else if (mask_clr_i) begin
        masked_d = 1'b0;
        mode_d   = MODE_EDGE;
      end
      if (unmask) begin
        irq_d  = pend_eff & ~pend_clr_i;
        pend_d = 1'b0;
      end else begin
        irq_d  = hit & ~masked_q;
        pend_d = pend_eff & ~pend_clr_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
      pv_q     <= '0;
      mode_q   <= MODE_EDGE;
      masked_q <= 1'b1;
      pend_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (sv_we_i) shadow_q <= sv_wdata_i;
      active_q <= active_d;
      pv_q     <= pv_d;
      mode_q   <= mode_d;
      masked_q <= masked_d;
      pend_q   <= pend_d;
      irq_q    <= irq_d;
    end
  end

  assign irq_o = irq_q;
  assign pv_o  = pv_q;
endmodule

// File: rtl/cnt_irq_top.sv
module cnt_irq_top #(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       evt_i,
  input  logic [NUM_CH-1:0]       sv_we_i,
  input  logic [CNT_W-1:0]        sv_wdata_i,
  input  logic                    refresh_i,
  input  logic [NUM_CH-1:0]       refresh_ctl_i,
  input  logic [NUM_CH-1:0]       mask_set_i,
  input  logic [NUM_CH-1:0]       mask_clr_i,
  input  logic [NUM_CH-1:0]       pend_clr_i,
  output logic [NUM_CH-1:0]       irq_o,
  output logic [NUM_CH*CNT_W-1:0] pv_o
);
  logic [NUM_CH-1:0] rise_w;
  logic [NUM_CH-1:0] ld_w;

  assign ld_w = {NUM_CH{refresh_i}} & ~refresh_ctl_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cnt_irq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (evt_i[c]),
      .rise_o (rise_w[c])
    );

    cnt_irq_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rise_i     (rise_w[c]),
      .sv_we_i    (sv_we_i[c]),
      .sv_wdata_i (sv_wdata_i),
      .load_i     (ld_w[c]),
      .mask_set_i (mask_set_i[c]),
      .mask_clr_i (mask_clr_i[c]),
      .pend_clr_i (pend_clr_i[c]),
      .irq_o      (irq_o[c]),
      .pv_o       (pv_o[c*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/cnt_irq_chk.sv
module cnt_irq_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_CH-1:0]       rise_i,
  input logic [NUM_CH-1:0]       ld_i,
  input logic [NUM_CH-1:0]       mask_clr_i,
  input logic [NUM_CH-1:0]       irq_i,
  input logic [NUM_CH*CNT_W-1:0] pv_i
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_one_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_i[c] |=> !rise_i[c]);

    p_pv_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rise_i[c] && !ld_i[c]) |=> $stable(pv_i[c*CNT_W +: CNT_W]));

    p_refresh_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_i[c] |=> !irq_i[c]);

    p_irq_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[c] |-> $past(rise_i[c] || mask_clr_i[c]));
  end
endmodule

bind cnt_irq_top cnt_irq_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rise_i     (rise_w),
  .ld_i       (ld_w),
  .mask_clr_i (mask_clr_i),
  .irq_i      (irq_o),
  .pv_i       (pv_o)
);

// File: tb/cnt_irq_top_tb_top.sv
`timescale 1ns/1ps
module cnt_irq_top_tb_top;
  localparam int N = 4;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   evt = '0, sv_we = '0, ctl = '1, mset = '0, mclr = '0, pclr = '0;
  logic [W-1:0]   wdata = '0;
  logic           refresh = 1'b0;
  logic [N-1:0]   irq;
  logic [N*W-1:0] pv;

  int n_tests = 0;
  int n_fail  = 0;
  int irq_cnt [N];
  bit done = 1'b0;

  always #5 clk = ~clk;

  cnt_irq_top #(.NUM_CH(N), .CNT_W(W), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .sv_we_i(sv_we), .sv_wdata_i(wdata),
    .refresh_i(refresh), .refresh_ctl_i(ctl), .mask_set_i(mset), .mask_clr_i(mclr),
    .pend_clr_i(pclr), .irq_o(irq), .pv_o(pv)
  );

  always @(negedge clk)
    for (int c = 0; c < N; c++) if (irq[c]) irq_cnt[c]++;

  function automatic int pv_of(int c);
    return int'(pv[c*W +: W]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge_pulse(input int c);
    @(negedge clk) evt[c] = 1'b1;
    repeat (2) @(negedge clk);
    evt[c] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_sv(input int c, input int v);
    @(negedge clk) begin sv_we = '0; sv_we[c] = 1'b1; wdata = W'(v); end
    @(negedge clk) sv_we = '0;
  endtask

  task automatic do_refresh(input logic [N-1:0] sel);
    @(negedge clk) begin refresh = 1'b1; ctl = sel; end
    @(negedge clk) begin refresh = 1'b0; ctl = '1; end
    @(negedge clk);
  endtask

  task automatic strobe(input logic [N-1:0] s, input logic [N-1:0] c, input logic [N-1:0] p);
    @(negedge clk) begin mset = s; mclr = c; pclr = p; end
    @(negedge clk) begin mset = '0; mclr = '0; pclr = '0; end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int c = 0; c < N; c++) chk("R1 pv after reset", pv_of(c), 0);
    chk("R1 irq after reset", int'(irq), 0);
    edge_pulse(3);
    chk("R1 masked at reset, no irq", irq_cnt[3], 0);
    chk("R1 per-edge mode holds pv", pv_of(3), 0);
  endtask

  task automatic t_refresh_sel;
    wr_sv(0, 4);
    wr_sv(1, 6);
    do_refresh(4'b1110);
    chk("R4 selected channel loads sv-1", pv_of(0), 3);
    chk("R4 unselected channel untouched", pv_of(1), 0);
    do_refresh(4'b1101);
    chk("R4 second channel loads", pv_of(1), 5);
    chk("R4 first channel untouched", pv_of(0), 3);
    do_refresh(4'b0111);
    chk("R4 refresh drops pending silently", irq_cnt[3], 0);
    chk("R6 zero set value reads all ones", pv_of(3), 255);
  endtask

  task automatic t_count;
    int base = irq_cnt[0];
    for (int i = 0; i < 3; i++) begin
      edge_pulse(0);
      chk("R5 decrement per edge", pv_of(0), 2 - i);
    end
    chk("R5 no irq before terminal", irq_cnt[0] - base, 0);
    edge_pulse(0);
    chk("R5 one irq pulse at terminal", irq_cnt[0] - base, 1);
    chk("R5 reload after terminal", pv_of(0), 3);
    @(negedge clk) evt[0] = 1'b1;
    repeat (12) @(negedge clk);
    evt[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 held level counts once", pv_of(0), 2);
    chk("R5 other channel independent", pv_of(1), 5);
  endtask

  task automatic t_shadow;
    int base = irq_cnt[0];
    wr_sv(0, 2);
    chk("R3 shadow write leaves pv", pv_of(0), 2);
    edge_pulse(0);
    edge_pulse(0);
    chk("R3 old count still running", pv_of(0), 0);
    chk("R3 no early irq", irq_cnt[0] - base, 0);
    edge_pulse(0);
    chk("R3 irq on old terminal", irq_cnt[0] - base, 1);
    chk("R3 reload uses latched value", pv_of(0), 3);
    do_refresh(4'b1110);
    chk("R3 new value after refresh", pv_of(0), 1);
  endtask

  task automatic t_collision;
    int base;
    wr_sv(0, 1);
    do_refresh(4'b1110);
    chk("R7 set value one gives pv 0", pv_of(0), 0);
    base = irq_cnt[0];
    @(negedge clk) evt[0] = 1'b1;
    @(negedge clk);
    @(negedge clk) begin evt[0] = 1'b0; refresh = 1'b1; ctl = 4'b1110; end
    @(negedge clk) begin refresh = 1'b0; ctl = '1; end
    repeat (3) @(negedge clk);
    chk("R7 edge lost to refresh, no irq", irq_cnt[0] - base, 0);
    chk("R7 pv reloaded", pv_of(0), 0);
    edge_pulse(0);
    chk("R7 following edge fires", irq_cnt[0] - base, 1);
  endtask

  task automatic t_wrap;
    int base = irq_cnt[2];
    wr_sv(2, 0);
    do_refresh(4'b1011);
    chk("R6 pv all ones after refresh", pv_of(2), 255);
    for (int i = 0; i < 255; i++) edge_pulse(2);
    chk("R6 pv reaches zero", pv_of(2), 0);
    chk("R6 no irq before 256th edge", irq_cnt[2] - base, 0);
    edge_pulse(2);
    chk("R6 irq on 256th edge", irq_cnt[2] - base, 1);
    chk("R6 reload to all ones", pv_of(2), 255);
  endtask

  task automatic t_mask;
    int base;
    wr_sv(0, 2);
    do_refresh(4'b1110);
    base = irq_cnt[0];
    strobe(4'b0001, 4'b0000, 4'b0000);
    edge_pulse(0);
    chk("R8 masked channel keeps counting", pv_of(0), 0);
    edge_pulse(0);
    chk("R8 masked terminal reloads", pv_of(0), 1);
    chk("R8 masked terminal gives no irq", irq_cnt[0] - base, 0);
    strobe(4'b0000, 4'b0001, 4'b0000);
    chk("R9 pending delivered on unmask", irq_cnt[0] - base, 1);
    edge_pulse(0);
    chk("R9 per-edge irq", irq_cnt[0] - base, 2);
    chk("R9 per-edge mode holds pv", pv_of(0), 1);
    edge_pulse(0);
    chk("R9 second per-edge irq", irq_cnt[0] - base, 3);
  endtask

  task automatic t_pend_clear;
    int base = irq_cnt[0];
    strobe(4'b0001, 4'b0000, 4'b0000);
    edge_pulse(0);
    chk("R10 masked edge gives no irq", irq_cnt[0] - base, 0);
    strobe(4'b0000, 4'b0000, 4'b0001);
    strobe(4'b0000, 4'b0001, 4'b0000);
    chk("R10 cleared pending not delivered", irq_cnt[0] - base, 0);
    edge_pulse(0);
    chk("R10 channel unmasked afterwards", irq_cnt[0] - base, 1);
  endtask

  task automatic t_priority;
    int base = irq_cnt[0];
    strobe(4'b0001, 4'b0001, 4'b0000);
    edge_pulse(0);
    chk("R11 set beats clear, stays masked", irq_cnt[0] - base, 0);
    strobe(4'b0000, 4'b0001, 4'b0001);
    chk("R11 clear-pending with unmask discards", irq_cnt[0] - base, 0);
    edge_pulse(0);
    chk("R11 unmasked after strobe", irq_cnt[0] - base, 1);
  endtask

  initial begin
    for (int c = 0; c < N; c++) irq_cnt[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_refresh_sel();
    t_count();
    t_shadow();
    t_collision();
    t_wrap();
    t_mask();
    t_pend_clear();
    t_priority();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule